// File: doc/BRIEF.md
# Decoded RAM and ROM Memory Subsystem

This block is the memory a small processor sees across a 1 KB address space. It holds four 128-byte RAM banks and one 512-byte ROM. The top address bit chooses between the RAM half and the ROM half. In the RAM half, the next two bits pick one bank through a one-hot decoder. The remaining low bits select a byte inside the chosen chip.

Each chip is enabled by a pair of selects: one active-high and one active-low. A chip that is not enabled puts no data on the shared read path. The outputs of all chips are merged by OR, with a drive flag standing in for a three-state bus.

Reads are combinational, and the data valid flag rises in the same cycle as the read strobe. RAM writes land on the rising clock edge. There is no back-pressure: the processor side may present a new access every cycle, and a read result is good for as long as the strobe and address are held. The ROM contents are a fixed arithmetic pattern of the address, so no image file is needed.

Top module: `mem_subsys`

## Requirements
- R1: Addresses 0x000 to 0x1FF reach RAM bank addr[8:7], byte addr[6:0], so bank k spans 0x080*k to 0x080*k+0x7F. Addresses 0x200 to 0x3FF reach the ROM at byte addr[8:0].
- R2: A chip responds only when its active-high select is 1 and its active-low select is 0. Every other select pair leaves that chip silent.
- R3: With rd_i=0 and wr_i=1 at a RAM address, wdata_i is stored at the rising clock edge, and later reads of that address return it.
- R4: With rd_i=1 and wr_i=1 at a RAM address, the access is a read: the old byte is returned and memory keeps it.
- R5: With rd_i=0, data_valid_o is 0 and rdata_o is 0x00 whatever wr_i is.
- R6: A ROM read at address A returns A[7:0] XOR 0xA5, further XORed with 0x3C when A[8] is 1. So 0x200 reads 0xA5 and 0x3FF reads 0x66.
- R7: A write to the ROM range changes nothing: no RAM byte, including the one with the same low nine address bits, is altered, and ROM reads are unchanged.
- R8: At most one chip drives read data in any cycle. data_valid_o equals rd_i, since every address maps to exactly one chip.
- R9: While rst_n is 0, no RAM write takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; RAM writes commit on its rising edge |
| rst_n | input | 1 | Active-low reset; blocks RAM writes while low |
| addr_i | input | 10 | Byte address |
| rd_i | input | 1 | Read strobe, active high |
| wr_i | input | 1 | Write strobe, active high |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, 0x00 when nothing drives |
| data_valid_o | output | 1 | High while a chip drives rdata_o |

## Verification
Read and write can fall in the same cycle when both strobes are high at a RAM address. The bench provokes this at a bank base whose byte it has just written. It then judges two things: that the returned byte is the old one, and that a plain read afterwards still returns it. The second collision is a write aimed at the ROM range that shares its low nine bits with a RAM byte already written. It is judged by reading back both that RAM byte and the ROM location.

// File: rtl/mem_sub_pkg.sv
package mem_sub_pkg;

  localparam int BYTE_W = 8;

  typedef logic [BYTE_W-1:0] byte_t;

  // ROM image generator: low address byte scrambled, upper half flipped.
  function automatic byte_t rom_pattern(input logic [15:0] idx);
    byte_t v;
    v = idx[7:0] ^ 8'hA5;
    if (idx[8]) v = v ^ 8'h3C;
    return v;
  endfunction

endpackage

// File: rtl/mem_bank_decode.sv
module mem_bank_decode #(
  parameter int SEL_W = 2,
  localparam int N_OUT = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic [N_OUT-1:0] hot_o
);

  for (genvar g = 0; g < N_OUT; g++) begin : g_dec
    assign hot_o[g] = (sel_i == SEL_W'(g));
  end

  always_comb begin
    if (!$isunknown(sel_i))
      AST_DEC_ONEHOT: assert ($onehot(hot_o)); // R1
  end

endmodule

// File: rtl/mem_ram_bank.sv
module mem_ram_bank
  import mem_sub_pkg::*;
#(
  parameter int AW = 7,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_hi_i,
  input  logic          cs_lo_n_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  byte_t         wdata_i,
  output byte_t         rdata_o,
  output logic          drive_o,
  output logic          we_o
);

  byte_t mem [DEPTH];
  logic  chip_on;

  assign chip_on = cs_hi_i & ~cs_lo_n_i;
  assign drive_o = chip_on & rd_i;
  assign we_o    = chip_on & ~rd_i & wr_i & rst_n;
  assign rdata_o = drive_o ? mem[addr_i] : '0;

  always_ff @(posedge clk) begin
    if (we_o) mem[addr_i] <= wdata_i;
  end

  AST_RAM_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    we_o |=> mem[$past(addr_i)] == $past(wdata_i)); // R3

  AST_RAM_READ_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_on && rd_i && wr_i) |=> mem[$past(addr_i)] == $past(mem[addr_i])); // R4

endmodule

// File: rtl/mem_rom.sv
module mem_rom
  import mem_sub_pkg::*;
#(
  parameter int AW = 9,
  localparam int DEPTH = 1 << AW
) (
  input  logic          cs_hi_i,
  input  logic          cs_lo_n_i,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  output byte_t         rdata_o,
  output logic          drive_o
);

  byte_t rom_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_img
    assign rom_q[g] = rom_pattern(16'(g));
  end

  assign drive_o = cs_hi_i & ~cs_lo_n_i & rd_i;
  assign rdata_o = drive_o ? rom_q[addr_i] : '0;

  always_comb begin
    if (drive_o && !$isunknown(addr_i))
      AST_ROM_IMAGE: assert (rdata_o == rom_pattern(16'(addr_i))); // R6
  end

endmodule

// File: rtl/mem_subsys.sv
module mem_subsys
  import mem_sub_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int RAM_AW = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              data_valid_o
);

  localparam int ROM_AW  = ADDR_W - 1;
  localparam int BSEL_W  = ROM_AW - RAM_AW;
  localparam int N_BANKS = 1 << BSEL_W;
  localparam int N_CHIPS = N_BANKS + 1;

  logic               rom_half;
  logic [N_BANKS-1:0] bank_hot;
  logic [N_BANKS-1:0] bank_we;
  logic [N_CHIPS-1:0] chip_drive;
  byte_t              chip_data [N_CHIPS];

  assign rom_half = addr_i[ADDR_W-1];

  mem_bank_decode #(.SEL_W(BSEL_W)) u_dec (
    .sel_i (addr_i[ROM_AW-1:RAM_AW]),
    .hot_o (bank_hot)
  );

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    mem_ram_bank #(.AW(RAM_AW)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_hi_i   (bank_hot[b]),
      .cs_lo_n_i (rom_half),
      .rd_i      (rd_i),
      .wr_i      (wr_i),
      .addr_i    (addr_i[RAM_AW-1:0]),
      .wdata_i   (wdata_i),
      .rdata_o   (chip_data[b]),
      .drive_o   (chip_drive[b]),
      .we_o      (bank_we[b])
    );
  end

  mem_rom #(.AW(ROM_AW)) u_rom (
    .cs_hi_i   (rom_half),
    .cs_lo_n_i (1'b0),
    .rd_i      (rd_i),
    .addr_i    (addr_i[ROM_AW-1:0]),
    .rdata_o   (chip_data[N_BANKS]),
    .drive_o   (chip_drive[N_BANKS])
  );

  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < N_CHIPS; c++) rdata_o = rdata_o | chip_data[c];
  end

  assign data_valid_o = |chip_drive;

  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chip_drive)); // R8

  AST_VALID_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid_o == rd_i); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |-> (rdata_o == '0 && !data_valid_o)); // R5

  AST_ROM_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && rom_half) |-> bank_we == '0); // R7

  AST_SELECT_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    rom_half |-> chip_drive[N_BANKS-1:0] == '0); // R2

  AST_RESET_NO_WRITE: assert property (@(posedge clk)
    !rst_n |-> bank_we == '0); // R9

endmodule

// File: tb/mem_subsys_tb.sv
module mem_subsys_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] addr = '0;
  logic       rd = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       dvalid;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mem_subsys u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr_i       (addr),
    .rd_i         (rd),
    .wr_i         (wr),
    .wdata_i      (wdata),
    .rdata_o      (rdata),
    .data_valid_o (dvalid)
  );

  typedef struct packed {
    logic       rd;
    logic       wr;
    logic [9:0] addr;
    logic [7:0] wd;
    logic       ev;
    logic [7:0] ed;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 10'h000, 8'h11, 1'b0, 8'h00}, // R3 R1 bank 0 base
    '{1'b0, 1'b1, 10'h07F, 8'h22, 1'b0, 8'h00}, // R3 bank 0 top
    '{1'b0, 1'b1, 10'h080, 8'h33, 1'b0, 8'h00}, // R3 bank 1 base
    '{1'b0, 1'b1, 10'h0FF, 8'h44, 1'b0, 8'h00}, // R3 bank 1 top
    '{1'b0, 1'b1, 10'h100, 8'h55, 1'b0, 8'h00}, // R3 bank 2 base
    '{1'b0, 1'b1, 10'h17F, 8'h66, 1'b0, 8'h00}, // R3 bank 2 top
    '{1'b0, 1'b1, 10'h180, 8'h77, 1'b0, 8'h00}, // R3 bank 3 base
    '{1'b0, 1'b1, 10'h1FF, 8'h88, 1'b0, 8'h00}, // R3 bank 3 top
    '{1'b1, 1'b0, 10'h000, 8'h00, 1'b1, 8'h11}, // R1 R2 R8 reads
    '{1'b1, 1'b0, 10'h07F, 8'h00, 1'b1, 8'h22},
    '{1'b1, 1'b0, 10'h080, 8'h00, 1'b1, 8'h33},
    '{1'b1, 1'b0, 10'h0FF, 8'h00, 1'b1, 8'h44},
    '{1'b1, 1'b0, 10'h100, 8'h00, 1'b1, 8'h55},
    '{1'b1, 1'b0, 10'h17F, 8'h00, 1'b1, 8'h66},
    '{1'b1, 1'b0, 10'h180, 8'h00, 1'b1, 8'h77},
    '{1'b1, 1'b0, 10'h1FF, 8'h00, 1'b1, 8'h88},
    '{1'b1, 1'b1, 10'h000, 8'hFF, 1'b1, 8'h11}, // R4 both strobes
    '{1'b1, 1'b0, 10'h000, 8'h00, 1'b1, 8'h11}, // R4 old byte kept
    '{1'b1, 1'b0, 10'h200, 8'h00, 1'b1, 8'hA5}, // R6 ROM base
    '{1'b1, 1'b0, 10'h3FF, 8'h00, 1'b1, 8'h66}, // R6 ROM top
    '{1'b1, 1'b0, 10'h2A7, 8'h00, 1'b1, 8'h02}, // R6
    '{1'b1, 1'b0, 10'h355, 8'h00, 1'b1, 8'hCC}, // R6 upper half
    '{1'b0, 1'b1, 10'h200, 8'h77, 1'b0, 8'h00}, // R7 write to ROM
    '{1'b1, 1'b0, 10'h000, 8'h00, 1'b1, 8'h11}, // R7 RAM alias intact
    '{1'b0, 1'b0, 10'h07F, 8'h00, 1'b0, 8'h00}  // R5 idle
  };

  logic [7:0] ref_mem [512];

  task automatic check(input string req, input logic [7:0] act,
                       input logic [7:0] exp, input logic av, input logic ev);
    n_vec++;
    if (act !== exp || av !== ev) begin
      n_bad++;
      $display("FAIL %s addr=%h data act=%h exp=%h valid act=%b exp=%b",
               req, addr, act, exp, av, ev);
    end
  endtask

  task automatic drive(input logic r, input logic w, input logic [9:0] a,
                       input logic [7:0] d);
    @(negedge clk);
    rd = r; wr = w; addr = a; wdata = d;
    #1;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R5 reset idle", rdata, 8'h00, dvalid, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].rd, VECS[i].wr, VECS[i].addr, VECS[i].wd);
      check($sformatf("vector %0d R1..R8", i), rdata, VECS[i].ed, dvalid, VECS[i].ev);
    end

    // R1 R3: full RAM sweep against a reference array
    for (int i = 0; i < 512; i++) begin
      ref_mem[i] = 8'((i * 7 + 3) ^ (i >> 3));
      drive(1'b0, 1'b1, 10'(i), ref_mem[i]);
    end
    for (int i = 0; i < 512; i++) begin
      drive(1'b1, 1'b0, 10'(i), 8'h00);
      check("R1 sweep", rdata, ref_mem[i], dvalid, 1'b1);
    end

    // R7: ROM untouched after write attempt
    drive(1'b0, 1'b1, 10'h3FF, 8'h00);
    drive(1'b1, 1'b0, 10'h3FF, 8'h00);
    check("R7 rom unchanged", rdata, 8'h66, dvalid, 1'b1);
    drive(1'b1, 1'b0, 10'h1FF, 8'h00);
    check("R7 ram alias", rdata, ref_mem[511], dvalid, 1'b1);

    // R5: write strobe alone gives no read data
    drive(1'b0, 1'b1, 10'h05A, 8'h3E);
    check("R5 write cycle quiet", rdata, 8'h00, dvalid, 1'b0);
    ref_mem[10'h05A] = 8'h3E;

    // R9: write attempted while in reset
    @(negedge clk);
    rst_n = 1'b0;
    drive(1'b0, 1'b1, 10'h07F, 8'hEE);
    @(negedge clk);
    wr = 1'b0;
    rst_n = 1'b1;
    drive(1'b1, 1'b0, 10'h07F, 8'h00);
    check("R9 no write in reset", rdata, ref_mem[127], dvalid, 1'b1);
    drive(1'b1, 1'b0, 10'h05A, 8'h00);
    check("R3 late write", rdata, 8'h3E, dvalid, 1'b1);

    drive(1'b0, 1'b0, 10'h000, 8'h00);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule